// File: doc/BRIEF.md
# Two-Phase Decimating Four-Tap Wavelet Analysis Filter

This block runs the analysis half of a one-level, one-dimensional wavelet split on a single image row. Each accepted beat carries two neighbouring pixels: the sample at an even position and the odd sample that follows it. The block returns one low-band coefficient and one high-band coefficient for that beat, so the output is already decimated by two. The low band uses a four-tap Daubechies kernel quantised to eleven fractional bits. The high band uses its alternating-sign mirror.

Each pair of pixels is split by phase. Even pixels meet the second and fourth taps and odd pixels meet the first and third. The trailing half of the sum is held in a register until the next pair arrives, and the next pair supplies the leading half. Because of this, every pair after the first one in a row yields a result in the following cycle. The row is treated as periodic. The first pair of each row is therefore kept, and one cycle after the last pair the block issues a closing result that folds the row end back onto the row start. A row of `ROW_LEN` pixels gives exactly `ROW_LEN/2` results. Rows may follow each other with no idle cycle between them.

Top module: `dwt4_pair_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_row_end`, `out_low` and `out_high` are all zero.
- R2: The first pair of a row produces no result in the following cycle. A pair is the first of its row when `in_row_start` is high, or when it follows a completed row or reset.
- R3: For pair index k ≥ 1 of a row, with pixels x, `out_low` in the next cycle is round((−265·x[2k+1] + 459·x[2k] + 1713·x[2k−1] + 989·x[2k−2]) / 128). The value is signed and has 4 fractional bits.
- R4: For the same pair, `out_high` in the same cycle is round((−989·x[2k+1] + 1713·x[2k] − 459·x[2k−1] − 265·x[2k−2]) / 128).
- R5: Two cycles after the last pair of a complete row is accepted, `out_valid` and `out_row_end` are both 1. In that cycle the R3 and R4 formulas hold with k = ROW_LEN/2 and indices taken modulo ROW_LEN, so x[1] and x[0] are taken from the start of the same row. `out_row_end` is 0 on every other result.
- R6: Rounding adds 64 and then shifts arithmetically right by 7, so ties round toward positive infinity.
- R7: A cycle with `in_valid` low changes no filter state and produces no result, except for a pending row-end result.
- R8: `in_row_start` in the middle of a row drops the partial row. No row-end result is produced for the dropped row, and the new pair starts a fresh row.
- R9: A complete row may be followed immediately by the next row's first pair, with or without `in_row_start`. The row-end result and the next row's results are not lost.
- R10: Every complete row produces exactly ROW_LEN/2 results, in pair order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A pixel pair is presented this cycle |
| in_row_start | input | 1 | The presented pair is the first of a new row |
| in_even | input | DATA_W | Pixel at the even position, unsigned |
| in_odd | input | DATA_W | Pixel at the following odd position, unsigned |
| out_valid | output | 1 | A result pair is on the outputs |
| out_low | output | OUT_W | Low-band coefficient, signed, OUT_FRAC fractional bits |
| out_high | output | OUT_W | High-band coefficient, signed, OUT_FRAC fractional bits |
| out_row_end | output | 1 | The result is the wrapped closing result of the row |

## Verification
The bench aims at the wrap result. A design that read the wrong stored pair, or the partial sum of the wrong row, would give a wrong closing value on the single-pixel impulse sweep, where each pixel position lands on exactly one tap. Rows are sent back to back, with and without the start strobe, and with idle gaps inside a row. A design that lost track of the pair count would shift every later result by one cycle, drop a result, or emit a result on a row's first pair. Rows are also aborted mid-way. A design that still closed the aborted row would output one result that was not expected. All-zero, full-scale and alternating rows cover the sign extension and rounding of the most positive and most negative sums.

// File: rtl/dwt4_pair_filter.sv
module dwt4_pair_filter #(
  parameter int ROW_LEN  = 8,
  parameter int DATA_W   = 8,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_row_start,
  input  logic [DATA_W-1:0]       in_even,
  input  logic [DATA_W-1:0]       in_odd,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_low,
  output logic signed [OUT_W-1:0] out_high,
  output logic                    out_row_end
);
  localparam int COEF_FRAC = 11;
  localparam int COEF_W    = 12;
  localparam int ACC_W     = DATA_W + COEF_W + 2;
  localparam int PAIRS     = ROW_LEN / 2;
  localparam int CNT_W     = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int RSH       = COEF_FRAC - OUT_FRAC;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (RSH - 1));

  localparam int H0 = -265;
  localparam int H1 = 459;
  localparam int H2 = 1713;
  localparam int H3 = 989;
  localparam int G0 = -H3;
  localparam int G1 = H2;
  localparam int G2 = -H1;
  localparam int G3 = H0;

  function automatic logic signed [ACC_W-1:0] cmul(input logic [DATA_W-1:0] x, input int c);
    logic signed [ACC_W-1:0] xs;
    logic signed [ACC_W-1:0] cs;
    xs = ACC_W'({1'b0, x});
    cs = ACC_W'(c);
    return xs * cs;
  endfunction

  function automatic logic signed [OUT_W-1:0] rnd(input logic signed [ACC_W-1:0] a);
    return OUT_W'((a + HALF) >>> RSH);
  endfunction

  logic [CNT_W-1:0]        cnt;
  logic [DATA_W-1:0]       first_e, first_o;
  logic signed [ACC_W-1:0] part_lo, part_hi;
  logic signed [OUT_W-1:0] wrap_lo, wrap_hi;
  logic                    wrap_pend;

  logic                    first_pair, last_pair;
  logic signed [ACC_W-1:0] lo_head, lo_tail, hi_head, hi_tail, fl_head, fh_head;

  assign first_pair = in_row_start || (cnt == '0);
  assign last_pair  = !in_row_start && (cnt == CNT_W'(PAIRS - 1));

  assign lo_head = cmul(in_odd, H0) + cmul(in_even, H1);
  assign lo_tail = cmul(in_odd, H2) + cmul(in_even, H3);
  assign hi_head = cmul(in_odd, G0) + cmul(in_even, G1);
  assign hi_tail = cmul(in_odd, G2) + cmul(in_even, G3);
  assign fl_head = cmul(first_o, H0) + cmul(first_e, H1);
  assign fh_head = cmul(first_o, G0) + cmul(first_e, G1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      first_e     <= '0;
      first_o     <= '0;
      part_lo     <= '0;
      part_hi     <= '0;
      wrap_lo     <= '0;
      wrap_hi     <= '0;
      wrap_pend   <= 1'b0;
      out_valid   <= 1'b0;
      out_row_end <= 1'b0;
      out_low     <= '0;
      out_high    <= '0;
    end else begin
      out_valid   <= 1'b0;
      out_row_end <= 1'b0;
      wrap_pend   <= 1'b0;
      if (wrap_pend) begin
        out_valid   <= 1'b1;
        out_row_end <= 1'b1;
        out_low     <= wrap_lo;
        out_high    <= wrap_hi;
      end
      if (in_valid) begin
        part_lo <= lo_tail;
        part_hi <= hi_tail;
        if (first_pair) begin
          first_e <= in_even;
          first_o <= in_odd;
          cnt     <= CNT_W'(1);
        end else begin
          out_valid   <= 1'b1;
          out_row_end <= 1'b0;
          out_low     <= rnd(part_lo + lo_head);
          out_high    <= rnd(part_hi + hi_head);
          if (last_pair) begin
            wrap_lo   <= rnd(lo_tail + fl_head);
            wrap_hi   <= rnd(hi_tail + fh_head);
            wrap_pend <= 1'b1;
            cnt       <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/dwt4_pair_filter_chk.sv
module dwt4_pair_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_row_start,
  input logic out_valid,
  input logic out_row_end
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !out_row_end)); // R1
  AST_FIRST_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row_start) |=> (!out_valid || out_row_end)); // R2
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid || out_row_end)); // R7
  AST_END_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_row_end |-> out_valid); // R5
  AST_END_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_row_end |-> $past(in_valid, 2)); // R5
  AST_END_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    out_row_end |=> !out_row_end); // R10
endmodule

bind dwt4_pair_filter dwt4_pair_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row_start(in_row_start),
  .out_valid(out_valid), .out_row_end(out_row_end)
);

// File: tb/dwt4_pair_filter_bench.sv
`timescale 1ns/1ps
module dwt4_pair_filter_bench;
  localparam int N  = 8;
  localparam int NP = N / 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_row_start = 1'b0;
  logic [7:0] in_even = '0, in_odd = '0;
  logic out_valid, out_row_end;
  logic signed [15:0] out_low, out_high;

  dwt4_pair_filter #(.ROW_LEN(N)) u_dwt4_pair_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row_start(in_row_start),
    .in_even(in_even), .in_odd(in_odd), .out_valid(out_valid),
    .out_low(out_low), .out_high(out_high), .out_row_end(out_row_end)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int q_cyc[$], q_lo[$], q_hi[$], q_end[$];
  int row[N];
  int seed = 7;

  function automatic int rnd7(int v);
    return (v + 64) >>> 7;
  endfunction

  function automatic int px(int i);
    return row[i % N];
  endfunction

  function automatic int ref_lo(int k);
    return rnd7(-265*px(2*k+1) + 459*px(2*k) + 1713*px(2*k-1) + 989*px(2*k-2));
  endfunction

  function automatic int ref_hi(int k);
    return rnd7(-989*px(2*k+1) + 1713*px(2*k) - 459*px(2*k-1) - 265*px(2*k-2));
  endfunction

  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 255;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        n_tests++;
        if (!out_valid || out_row_end != q_end[0][0] ||
            int'(out_low) != q_lo[0] || int'(out_high) != q_hi[0]) begin
          n_fail++;
          $display("FAIL %s cyc=%0d actual v=%0d end=%0d lo=%0d hi=%0d expected v=1 end=%0d lo=%0d hi=%0d",
                   q_end[0] ? "R5 R6" : "R3 R4 R6", cyc, out_valid, out_row_end,
                   out_low, out_high, q_end[0], q_lo[0], q_hi[0]);
        end
        void'(q_cyc.pop_front()); void'(q_lo.pop_front());
        void'(q_hi.pop_front());  void'(q_end.pop_front());
      end else if (out_valid) begin
        n_tests++; n_fail++;
        $display("FAIL R2 R7 R8 cyc=%0d actual unexpected result lo=%0d hi=%0d expected no result",
                 cyc, out_low, out_high);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); in_valid = 1'b0; in_row_start = 1'b0;
    end
  endtask

  task automatic send_row(input int npairs, input bit rs, input int gap);
    for (int k = 0; k < npairs; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_row_start = rs && (k == 0);
      in_even = 8'(row[2*k]); in_odd = 8'(row[2*k+1]);
      if (k >= 1) begin
        q_cyc.push_back(cyc + 1); q_lo.push_back(ref_lo(k));
        q_hi.push_back(ref_hi(k)); q_end.push_back(0);
      end
      if (k == NP - 1) begin
        q_cyc.push_back(cyc + 2); q_lo.push_back(ref_lo(NP));
        q_hi.push_back(ref_hi(NP)); q_end.push_back(1);
      end
      if (gap > 0 && k < npairs - 1) idle(gap);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL R10 watchdog actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid || out_row_end || out_low != 0 || out_high != 0) begin
      n_fail++;
      $display("FAIL R1 actual v=%0d lo=%0d hi=%0d expected 0 0 0", out_valid, out_low, out_high);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if (out_valid || out_row_end) begin
      n_fail++;
      $display("FAIL R1 actual v=%0d end=%0d after reset expected 0 0", out_valid, out_row_end);
    end

    foreach (row[i]) row[i] = 0;
    send_row(NP, 1, 0);
    foreach (row[i]) row[i] = 255;
    send_row(NP, 0, 0);                     // R9 no strobe, back to back
    foreach (row[i]) row[i] = (i % 2) ? 255 : 0;
    send_row(NP, 1, 1);
    foreach (row[i]) row[i] = (i % 2) ? 0 : 255;
    send_row(NP, 1, 0);
    foreach (row[i]) row[i] = i * 31;
    send_row(NP, 0, 2);

    for (int p = 0; p < N; p++) begin        // impulse sweep: each tap and the wrap
      foreach (row[i]) row[i] = (i == p) ? 255 : 0;
      send_row(NP, p % 2, 0);
    end

    for (int r = 0; r < 60; r++) begin
      foreach (row[i]) row[i] = next_rand();
      send_row(NP, r % 2, r % 3);
      if (r % 5 == 4) idle(r % 4);
    end

    foreach (row[i]) row[i] = next_rand();  // R8 dropped partial rows
    send_row(2, 1, 0);
    foreach (row[i]) row[i] = next_rand();
    send_row(NP, 1, 0);
    foreach (row[i]) row[i] = next_rand();
    send_row(NP - 1, 1, 1);
    foreach (row[i]) row[i] = next_rand();
    send_row(NP, 1, 0);

    idle(10);
    n_tests++;
    if (q_cyc.size() != 0) begin
      n_fail++;
      $display("FAIL R10 actual %0d results missing expected 0", q_cyc.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule